// File: doc/BRIEF.md
# Network Adapter Host Control and Status Registers

This block is the small I/O-mapped register window that a host processor sees for a network adapter. Over an eight-byte window it returns the adapter's 48-bit station address, one control/status byte and a revision byte. The station address and revision code are fixed at build time through parameters. No writable storage backs them.

The control byte drives two lines to the on-board network coprocessor: a reset line and a channel-attention line. Both are plain held levels. The host raises a line by writing a one and lowers it only by writing a zero. The same byte holds an interrupt-enable bit. It also shows, with no latching, the live state of the coprocessor's interrupt line.

The host interrupt request is the coprocessor interrupt gated by the enable bit. It is level sensitive and is presented as an active-low drive enable. Several adapters can therefore share one open-collector request line. The request drops as soon as the coprocessor releases its interrupt.

Top module: `nic_ctl_regs`

## Requirements
- R1: A read at offsets 0 to 5 returns one byte of the STATION_ADDR parameter. Offset 0 returns bits 47:40, and each higher offset returns the next lower byte, so offset 5 returns bits 7:0.
- R2: A read at offset 7 returns the REV_CODE parameter in bits 7:4, with bits 3:0 reading zero. The default REV_CODE is Fh, so the default read value is F0h.
- R3: Offset 6 is the control byte. Bit 0 is coprocessor reset and drives cop_reset_o. Bit 1 is channel attention and drives cop_attn_o. Bit 2 is interrupt enable. A write at offset 6 loads all three bits on the clock edge of the write, and a read returns them in the same positions.
- R4: Reset and channel attention are held levels, not pulses. Each one keeps its written value through any number of cycles until a later write at offset 6 changes it.
- R5: Bit 3 of a read at offset 6 equals cop_irq_i in the same cycle, with no latching. Bits 7:4 of that read are zero. Writes do not affect bit 3.
- R6: The interrupt drive output irq_drive_n is low exactly when cop_irq_i is high and the interrupt-enable bit is set. It follows cop_irq_i combinationally.
- R7: While rst_n is low at a clock edge, the block sets coprocessor reset to 1, channel attention to 0 and interrupt enable to 0.
- R8: Writes at offsets 0 to 5 and 7 are ignored. After such a write, the control bits, the control outputs and the read values at every offset are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 3 | Register offset for reads and writes |
| host_wr | input | 1 | Write strobe, sampled on the clock edge |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Combinational read data for host_addr |
| cop_irq_i | input | 1 | Interrupt line from the network coprocessor |
| cop_reset_o | output | 1 | Held reset level to the coprocessor |
| cop_attn_o | output | 1 | Held channel-attention level to the coprocessor |
| irq_drive_n | output | 1 | Active-low drive enable for the shared interrupt line |

## Verification
On every cycle, the assertions check four things. A control write loads the written bits. The reset and attention levels stay put when offset 6 is not written. Writes to other offsets leave the enable untouched. The status bit and the interrupt drive track the coprocessor line in the same cycle. Only the bench scenarios can show the rest:
- the exact byte order of the station address and the revision value;
- the values set by reset;
- that every read value survives writes to the read-only offsets.

The bench sweeps every control pattern and every combination of interrupt and enable to cover these.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;

    typedef struct packed {
        logic ie;
        logic attn;
        logic rst;
    } ctl_t;

    localparam int CTL_BITS = 3;
    localparam int IRQ_BIT  = 3;

endpackage

// File: rtl/nic_addr_rom.sv
module nic_addr_rom #(
    parameter int          ADDR_W     = 3,
    parameter int          DATA_W     = 8,
    parameter int          ADDR_BYTES = 6,
    parameter logic [47:0] STATION    = 48'h02A1B2C3D4E5
) (
    input  logic [ADDR_W-1:0] idx,
    output logic [DATA_W-1:0] byte_o
);
    logic [DATA_W-1:0] bytes_w [ADDR_BYTES];

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_byte
        assign bytes_w[g] = STATION[(ADDR_BYTES-1-g)*DATA_W +: DATA_W];
    end

    always_comb begin
        byte_o = '0;
        for (int k = 0; k < ADDR_BYTES; k++) begin
            if (idx == ADDR_W'(k)) byte_o = bytes_w[k];
        end
    end
endmodule

// File: rtl/nic_ctl_reg.sv
module nic_ctl_reg
    import nic_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  ctl_t wr_val,
    output ctl_t ctl_q
);
    typedef struct packed {
        ctl_t ctl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hit) st_d.ctl = wr_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctl.rst  <= 1'b1;
            st_q.ctl.attn <= 1'b0;
            st_q.ctl.ie   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_q = st_q.ctl;
endmodule

// File: rtl/nic_irq_gate.sv
module nic_irq_gate (
    input  logic cop_irq,
    input  logic enable,
    output logic drive_n
);
    logic req_w;
    assign req_w   = cop_irq & enable;
    assign drive_n = ~req_w;
endmodule

// File: rtl/nic_ctl_regs.sv
module nic_ctl_regs
    import nic_regs_pkg::*;
#(
    parameter int          ADDR_W   = 3,
    parameter int          DATA_W   = 8,
    parameter logic [47:0] STATION_ADDR = 48'h02A1B2C3D4E5,
    parameter logic [3:0]  REV_CODE = 4'hF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              cop_irq_i,
    output logic              cop_reset_o,
    output logic              cop_attn_o,
    output logic              irq_drive_n
);
    localparam int ADDR_BYTES = 6;
    localparam logic [ADDR_W-1:0] CTL_OFF = ADDR_W'(ADDR_BYTES);
    localparam logic [ADDR_W-1:0] REV_OFF = ADDR_W'(ADDR_BYTES + 1);

    logic [DATA_W-1:0] rom_byte;
    ctl_t              ctl_q;
    logic              int_en;
    logic              wr_hit;
    logic              wdata_unused;

    assign wr_hit       = host_wr && (host_addr == CTL_OFF);
    assign wdata_unused = ^host_wdata[DATA_W-1:CTL_BITS];

    nic_addr_rom #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .ADDR_BYTES(ADDR_BYTES), .STATION(STATION_ADDR)
    ) u_rom (
        .idx(host_addr), .byte_o(rom_byte)
    );

    nic_ctl_reg u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit),
        .wr_val(ctl_t'(host_wdata[CTL_BITS-1:0])), .ctl_q(ctl_q)
    );

    assign int_en      = ctl_q.ie;
    assign cop_reset_o = ctl_q.rst;
    assign cop_attn_o  = ctl_q.attn;

    nic_irq_gate u_irq (
        .cop_irq(cop_irq_i), .enable(int_en), .drive_n(irq_drive_n)
    );

    always_comb begin
        host_rdata = '0;
        if (host_addr == CTL_OFF) begin
            host_rdata[CTL_BITS-1:0] = ctl_q;
            host_rdata[IRQ_BIT]      = cop_irq_i;
        end else if (host_addr == REV_OFF) begin
            host_rdata[DATA_W-1:DATA_W-4] = REV_CODE;
        end else begin
            host_rdata = rom_byte;
        end
    end
endmodule

// File: rtl/nic_ctl_regs_chk.sv
module nic_ctl_regs_chk #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_wr,
    input logic [DATA_W-1:0] host_wdata,
    input logic [DATA_W-1:0] host_rdata,
    input logic              cop_irq_i,
    input logic              cop_reset_o,
    input logic              cop_attn_o,
    input logic              irq_drive_n,
    input logic              int_en
);
    localparam logic [ADDR_W-1:0] CTL_OFF = ADDR_W'(6);

    // R3
    ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == CTL_OFF) |=>
            (cop_reset_o == $past(host_wdata[0])) && (cop_attn_o == $past(host_wdata[1])));

    // R4
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_addr == CTL_OFF) |=> $stable(cop_reset_o) && $stable(cop_attn_o));

    // R8
    ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr != CTL_OFF) |=> $stable(int_en));

    // R5
    live_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == CTL_OFF) |-> (host_rdata[3] == cop_irq_i));

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_drive_n == !(cop_irq_i && int_en));
endmodule

bind nic_ctl_regs nic_ctl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .cop_irq_i(cop_irq_i),
    .cop_reset_o(cop_reset_o), .cop_attn_o(cop_attn_o),
    .irq_drive_n(irq_drive_n), .int_en(int_en)
);

// File: tb/nic_ctl_regs_test.sv
module nic_ctl_regs_test;
    localparam logic [47:0] MAC = 48'h02A1B2C3D4E5;
    localparam logic [3:0]  REV = 4'hF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       cop_irq_i = 1'b0;
    logic       cop_reset_o, cop_attn_o, irq_drive_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nic_ctl_regs #(.STATION_ADDR(MAC), .REV_CODE(REV)) uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .cop_irq_i(cop_irq_i),
        .cop_reset_o(cop_reset_o), .cop_attn_o(cop_attn_o), .irq_drive_n(irq_drive_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        host_addr = a; #1;
        d = host_rdata;
    endtask

    function automatic logic [7:0] mac_byte(input int k);
        return 8'(MAC >> (8 * (5 - k)));
    endfunction

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] snap [8];
        repeat (3) @(posedge clk);
        #1;
        // R7 reset state
        check("R7 reset line", {7'd0, cop_reset_o}, 8'd1);
        check("R7 attention line", {7'd0, cop_attn_o}, 8'd0);
        rd(3'd6, v);
        check("R7 ctl readback", v, 8'h01);
        check("R7 irq drive idle", {7'd0, irq_drive_n}, 8'd1);
        @(negedge clk); rst_n = 1'b1;

        // R1 station address order
        for (int k = 0; k < 6; k++) begin
            rd(3'(k), v);
            check("R1 station byte", v, mac_byte(k));
        end
        // R2 revision
        rd(3'd7, v);
        check("R2 revision", v, {REV, 4'h0});

        // R3 / R4 exhaustive control patterns
        for (int p = 0; p < 8; p++) begin
            wr(3'd6, 8'(p) | 8'hF0);
            rd(3'd6, v);
            check("R3 ctl readback", v, 8'(p));
            check("R3 reset out", {7'd0, cop_reset_o}, 8'(p & 1));
            check("R3 attn out", {7'd0, cop_attn_o}, 8'((p >> 1) & 1));
            repeat (5) @(posedge clk);
            #1;
            check("R4 reset held", {7'd0, cop_reset_o}, 8'(p & 1));
            check("R4 attn held", {7'd0, cop_attn_o}, 8'((p >> 1) & 1));
        end

        // R5 / R6 interrupt and enable sweep
        for (int e = 0; e < 2; e++) begin
            wr(3'd6, e[0] ? 8'h04 : 8'h00);
            for (int q = 0; q < 2; q++) begin
                @(negedge clk);
                cop_irq_i = q[0];
                rd(3'd6, v);
                check("R5 live status", v, {4'd0, q[0], e[0], 2'b00});
                check("R6 irq drive", {7'd0, irq_drive_n}, {7'd0, ~(q[0] & e[0])});
            end
        end
        // R5 drop with no clock edge in between
        wr(3'd6, 8'h04);
        @(negedge clk);
        cop_irq_i = 1'b1; #0.5;
        check("R6 drive asserted", {7'd0, irq_drive_n}, 8'd0);
        cop_irq_i = 1'b0; #0.5;
        check("R6 drive released", {7'd0, irq_drive_n}, 8'd1);
        rd(3'd6, v);
        check("R5 status cleared", v, 8'h04);

        // R8 writes to read-only offsets
        wr(3'd6, 8'h05);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), snap[a]);
        end
        for (int a = 0; a < 8; a++) begin
            if (a != 6) begin
                wr(3'(a), 8'hFF);
                wr(3'(a), 8'h00);
                for (int b = 0; b < 8; b++) begin
                    rd(3'(b), v);
                    check("R8 read value unchanged", v, snap[b]);
                end
                check("R8 reset unchanged", {7'd0, cop_reset_o}, 8'd1);
                check("R8 attn unchanged", {7'd0, cop_attn_o}, 8'd0);
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule